// File: doc/BRIEF.md
# Serial SRAM Command Slave

This block is the target side of a single-lane serial memory link in SPI mode 0. A host lowers chip select and sends an 8-bit opcode, then for array accesses a 24-bit address, then data. Every field is sent MSB first on the serial input and is sampled when SCK rises. Read data returns on the serial output, which changes after SCK falls. The block holds a byte-wide on-chip array, an address counter and a two-bit addressing mode. The mode chooses between a single-byte transfer, wrap-around inside a 32-byte page, and a run over the whole array that rolls over at the top.

All link pins are treated as synchronous samples in the block's own clock domain, so the block needs a system clock several times faster than SCK. Each SCK half period must last at least two `clk_i` cycles. The output enable is separate from the data pin, so a pad cell or a shared bus can tri-state the line. A pause input suspends a transfer without losing its place. `ADDR_W` sets the array depth. A value of 17 gives the full 128 KB array. The default is smaller so that the array stays cheap to elaborate, and the unused upper address bits are then ignored.

Top module: `serial_sram_slave`

## Requirements
- R1: Opcodes are 8 bits, MSB first, sampled on SCK rising edges: 0x03 reads the array, 0x02 writes it, 0x05 reads the mode register and 0x01 writes it. READ and WRITE are followed by a 24-bit address, MSB first.
- R2: Only the low `ADDR_W` bits of the 24-bit address select a location; the upper bits are ignored.
- R3: Read data leaves MSB first on `so_o`, which is updated after SCK falls. The first data bit is valid after the fall that follows the last address bit, and `so_oe_o` is high while read or mode data is being shifted out.
- R4: A write stores each data byte once its eighth bit has been sampled. A byte cut short by chip select rising is discarded and leaves its location unchanged.
- R5: Mode register bits [7:6] select addressing: 00 byte, 10 page, 01 sequential, 11 reserved (stored, and it advances like sequential). Reset value is 01. A mode read returns the two mode bits with bits [5:0] as zero, whatever was written to them.
- R6: In byte mode one data byte follows the address. Later write bits are ignored, and during a read `so_oe_o` drops at the next SCK fall.
- R7: In page mode the address steps through a 32-byte page and wraps from offset 31 to offset 0 of the same page.
- R8: In sequential mode the address crosses page boundaries and rolls over from the highest location to 0.
- R9: Chip select high ends any command and drops `so_oe_o`. After reset, a falling edge of chip select is needed before any command is accepted; a command sent while it stayed low from reset has no effect.
- R10: While the pause input is low, `so_oe_o` is low and SCK and serial input activity is ignored. Once the pause ends, the transfer continues from the same bit.
- R11: A pause change takes effect only while SCK is low. A pause started while SCK is high lets the next SCK fall take effect and only then holds the transfer.
- R12: Opcode 0xFF and any other undefined opcode are ignored until chip select rises, with no effect on the mode register or the array and with `so_oe_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the link |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, idle low |
| si_i | input | 1 | Serial data from host |
| hold_ni | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data to host |
| so_oe_o | output | 1 | Output enable for `so_o` |

## Verification
Two events can land in the same cycle: a sampled SCK edge, and a pause request that arrives while SCK is still high. The bench lowers the pause input right after a read-data rise. It then drops SCK and pulses SCK and the serial input while paused, and releases the pause with SCK low. The reference model expects the bit after the interrupted one, so a design that freezes at once, or one that counts the pulses made during the pause, shows the wrong bit on every clock compare.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned ADDR_FIELD_W = 24;

  localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;
  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;
  localparam logic [BYTE_W-1:0] OP_RDMR  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WRMR  = 8'h01;

  typedef enum logic [1:0] {
    MODE_BYTE = 2'b00,
    MODE_SEQ  = 2'b01,
    MODE_PAGE = 2'b10,
    MODE_RSVD = 2'b11
  } ssr_mode_e;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_WDAT,
    ST_RDAT,
    ST_MWR,
    ST_MRD,
    ST_IGNORE
  } ssr_state_e;
endpackage

// File: rtl/ssr_pins.sv
module ssr_pins (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  output logic sel_o,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q, cs_q, armed_q, hold_q;

  // cs_q resets low: chip select held low through reset gives no falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b0;
      armed_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      if (cs_ni)               armed_q <= 1'b0;
      else if (cs_q)           armed_q <= 1'b1;
      // pause state may only change while SCK is low
      if (!sck_i)              hold_q  <= ~hold_ni;
    end
  end

  assign sel_o  = armed_q & ~cs_ni;
  assign rise_o = sel_o & ~hold_q &  sck_i & ~sck_q;
  assign fall_o = sel_o & ~hold_q & ~sck_i &  sck_q;
endmodule

// File: rtl/ssr_addr_ctr.sv
module ssr_addr_ctr
  import ssr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_i,
  input  ssr_mode_e         mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] addr_nxt_o
);
  logic [ADDR_W-1:0] addr_q, addr_d, addr_lin, addr_pg;
  logic [PAGE_W-1:0] off_inc;

  assign addr_lin = addr_q + ADDR_W'(1);
  assign off_inc  = addr_q[PAGE_W-1:0] + PAGE_W'(1);

  generate
    if (PAGE_W < ADDR_W) begin : g_paged
      assign addr_pg = {addr_q[ADDR_W-1:PAGE_W], off_inc};
    end else begin : g_flat
      assign addr_pg = addr_lin;
    end
  endgenerate

  always_comb begin
    addr_d = addr_q;
    if (load_i) begin
      addr_d = load_val_i;
    end else if (step_i) begin
      addr_d = (mode_i == MODE_PAGE) ? addr_pg : addr_lin;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o     = addr_q;
  assign addr_nxt_o = addr_d;
endmodule

// File: rtl/ssr_mem.sv
module ssr_mem #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] arr_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) arr_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (re_i) rdata_o <= arr_q[addr_i];
  end
endmodule

// File: rtl/serial_sram_slave.sv
module serial_sram_slave
  import ssr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned PAGE_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_ni,
  output logic so_o,
  output logic so_oe_o
);
  localparam int unsigned CNT_W  = $clog2(ADDR_FIELD_W);
  localparam int unsigned SH_W   = (ADDR_W - 1 > BYTE_W - 1) ? ADDR_W - 1 : BYTE_W - 1;
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_FIELD_W - 1);

  logic sel, rise, fall;

  ssr_state_e        state_q, state_d;
  ssr_mode_e         mode_q, mode_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic [BYTE_W-1:0] out_q, out_d;
  logic              drive_q, drive_d;
  logic              op_rd_q, op_rd_d;

  logic [BYTE_W-1:0] bits_in;
  logic [ADDR_W-1:0] addr_in;
  logic              ctr_load, ctr_step;
  logic [ADDR_W-1:0] addr_q, addr_nxt, mem_addr;
  logic              mem_we, mem_re;
  logic [BYTE_W-1:0] mem_rdata;

  ssr_pins i_pins (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .sck_i   (sck_i),
    .hold_ni (hold_ni),
    .sel_o   (sel),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  ssr_addr_ctr #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) i_addr_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctr_load),
    .load_val_i (addr_in),
    .step_i     (ctr_step),
    .mode_i     (mode_q),
    .addr_o     (addr_q),
    .addr_nxt_o (addr_nxt)
  );

  ssr_mem #(
    .ADDR_W (ADDR_W),
    .DATA_W (BYTE_W)
  ) i_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .re_i    (mem_re),
    .addr_i  (mem_addr),
    .wdata_i (bits_in),
    .rdata_o (mem_rdata)
  );

  // incoming byte/address including the bit sampled on this rise
  assign bits_in = {sh_q[BYTE_W-2:0], si_i};
  assign addr_in = {sh_q[ADDR_W-2:0], si_i};
  // a write uses the current pointer; a read prefetches the next one
  assign mem_addr = mem_we ? addr_q : addr_nxt;

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    out_d    = out_q;
    drive_d  = drive_q;
    op_rd_d  = op_rd_q;
    mem_we   = 1'b0;
    mem_re   = 1'b0;
    ctr_load = 1'b0;
    ctr_step = 1'b0;

    if (!sel) begin
      state_d = ST_CMD;
      cnt_d   = '0;
      drive_d = 1'b0;
    end else begin
      if (rise) begin
        sh_d  = {sh_q[SH_W-2:0], si_i};
        cnt_d = cnt_q + CNT_W'(1);
        unique case (state_q)
          ST_CMD: if (cnt_q == BYTE_LAST) begin
            cnt_d = '0;
            unique case (bits_in)
              OP_READ:  begin state_d = ST_ADDR; op_rd_d = 1'b1; end
              OP_WRITE: begin state_d = ST_ADDR; op_rd_d = 1'b0; end
              OP_RDMR:  state_d = ST_MRD;
              OP_WRMR:  state_d = ST_MWR;
              default:  state_d = ST_IGNORE;
            endcase
          end
          ST_ADDR: if (cnt_q == ADDR_LAST) begin
            cnt_d    = '0;
            ctr_load = 1'b1;
            if (op_rd_q) begin
              mem_re  = 1'b1;
              state_d = ST_RDAT;
            end else begin
              state_d = ST_WDAT;
            end
          end
          ST_WDAT: if (cnt_q == BYTE_LAST) begin
            cnt_d    = '0;
            mem_we   = 1'b1;
            ctr_step = 1'b1;
            if (mode_q == MODE_BYTE) state_d = ST_IGNORE;
          end
          ST_RDAT: if (cnt_q == BYTE_LAST) begin
            cnt_d = '0;
            if (mode_q == MODE_BYTE) begin
              state_d = ST_IGNORE;
            end else begin
              ctr_step = 1'b1;
              mem_re   = 1'b1;
            end
          end
          ST_MWR: if (cnt_q == BYTE_LAST) begin
            mode_d  = ssr_mode_e'(bits_in[BYTE_W-1 -: 2]);
            state_d = ST_IGNORE;
          end
          ST_MRD: if (cnt_q == BYTE_LAST) state_d = ST_IGNORE;
          default: cnt_d = cnt_q;
        endcase
      end

      if (fall) begin
        unique case (state_q)
          ST_RDAT: begin
            drive_d = 1'b1;
            out_d   = (cnt_q == '0) ? mem_rdata : {out_q[BYTE_W-2:0], 1'b0};
          end
          ST_MRD: begin
            drive_d = 1'b1;
            out_d   = (cnt_q == '0) ? {mode_q, {(BYTE_W-2){1'b0}}}
                                    : {out_q[BYTE_W-2:0], 1'b0};
          end
          default: drive_d = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      mode_q  <= MODE_SEQ;
      cnt_q   <= '0;
      sh_q    <= '0;
      out_q   <= '0;
      drive_q <= 1'b0;
      op_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      out_q   <= out_d;
      drive_q <= drive_d;
      op_rd_q <= op_rd_d;
    end
  end

  assign so_o    = out_q[BYTE_W-1];
  assign so_oe_o = drive_q & hold_ni;
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker
  import ssr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned PAGE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              sck_i,
  input logic              hold_ni,
  input logic              so_oe_i,
  input logic              rise_i,
  input logic              mem_we_i,
  input logic              ctr_step_i,
  input ssr_mode_e         mode_i,
  input ssr_state_e        state_i,
  input logic [ADDR_W-1:0] addr_i
);
  assert_cs_high_floats_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !so_oe_i);

  assert_write_needs_select_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> !cs_ni);

  assert_pause_blocks_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_ni && !sck_i) |=> !rise_i);

  assert_byte_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && mode_i == MODE_BYTE) |=> (state_i == ST_IGNORE || state_i == ST_CMD));

  assert_page_stays_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctr_step_i && mode_i == MODE_PAGE)
      |=> addr_i[ADDR_W-1:PAGE_W] == $past(addr_i[ADDR_W-1:PAGE_W]));

  assert_seq_linear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctr_step_i && mode_i == MODE_SEQ) |=> addr_i == $past(addr_i) + ADDR_W'(1));
endmodule

bind serial_sram_slave ssr_checker #(
  .ADDR_W (ADDR_W),
  .PAGE_W (PAGE_W)
) i_ssr_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .sck_i      (sck_i),
  .hold_ni    (hold_ni),
  .so_oe_i    (so_oe_o),
  .rise_i     (rise),
  .mem_we_i   (mem_we),
  .ctr_step_i (ctr_step),
  .mode_i     (mode_q),
  .state_i    (state_q),
  .addr_i     (addr_q)
);

// File: tb/test_serial_sram_slave.sv
`timescale 1ns/1ps
module test_serial_sram_slave;
  localparam int ADDR_W = 11;
  localparam int MASK   = (1 << ADDR_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic hold_n = 1'b1;
  logic so, so_oe;

  always #2 clk = ~clk;

  serial_sram_slave #(.ADDR_W(ADDR_W), .PAGE_W(5)) i_serial_sram_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .hold_ni(hold_n), .so_o(so), .so_oe_o(so_oe)
  );

  // reference model
  logic [7:0] mdl_mem [int];
  int         mdl_mode = 1;
  logic exp_oe = 1'b0, exp_so = 1'b0, exp_kn = 1'b0;
  int   settle = 4;
  bit   cmp_on = 1'b0;
  bit   done = 1'b0;
  string cur_req = "R9";
  int vectors = 0, errors = 0;

  always @(negedge clk) begin
    if (cmp_on) begin
      if (settle > 0) settle--;
      else begin
        vectors++;
        if (so_oe !== exp_oe) begin
          errors++;
          $display("FAIL %s: so_oe=%b expected %b at %0t", cur_req, so_oe, exp_oe, $time);
        end else if (exp_oe && exp_kn && so !== exp_so) begin
          errors++;
          $display("FAIL %s: so=%b expected %b at %0t", cur_req, so, exp_so, $time);
        end
      end
    end
  end

  function automatic int adv(input int a);
    if (mdl_mode == 2) return (a & ~31) | ((a + 1) & 31);
    return (a + 1) & MASK;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fall_half(input logic b, input logic eo, input logic es, input logic ek);
    @(negedge clk); sck = 1'b0; si = b; exp_oe = eo; exp_so = es; exp_kn = ek; settle = 2;
    wait_n(3);
  endtask

  task automatic rise_half();
    @(negedge clk); sck = 1'b1; settle = 2;
    wait_n(3);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin fall_half(v[i], 1'b0, 1'b0, 1'b0); rise_half(); end
  endtask

  task automatic send_addr(input logic [23:0] a);
    for (int i = 23; i >= 0; i--) begin fall_half(a[i], 1'b0, 1'b0, 1'b0); rise_half(); end
  endtask

  task automatic cs_low();
    @(negedge clk); cs_n = 1'b0; exp_oe = 1'b0; settle = 2;
    wait_n(3);
  endtask

  task automatic cs_high();
    @(negedge clk); cs_n = 1'b1; sck = 1'b0; exp_oe = 1'b0; settle = 2;
    wait_n(4);
  endtask

  // pause with SCK low, junk activity on SCK/SI, resume with SCK low
  task automatic pause_low(input logic b);
    logic keep;
    keep = exp_oe;
    @(negedge clk); hold_n = 1'b0; exp_oe = 1'b0; settle = 2;
    wait_n(3);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); sck = 1'b1; si = ~b; settle = 2; wait_n(2);
      @(negedge clk); sck = 1'b0; settle = 2; wait_n(2);
    end
    @(negedge clk); si = b; hold_n = 1'b1; exp_oe = keep; settle = 2;
    wait_n(3);
  endtask

  task automatic do_write(input logic [23:0] a24, input logic [7:0] d[$],
                          input int hk, input int hidx, input int tail, input string rq);
    int a;
    cur_req = rq;
    cs_low(); send_byte(8'h02); send_addr(a24);
    for (int k = 0; k < d.size(); k++)
      for (int i = 7; i >= 0; i--) begin
        fall_half(d[k][i], 1'b0, 1'b0, 1'b0);
        if (hk == 1 && hidx == k * 8 + (7 - i)) pause_low(d[k][i]);
        rise_half();
      end
    for (int t = 0; t < tail; t++) begin fall_half(1'b1, 1'b0, 1'b0, 1'b0); rise_half(); end
    cs_high();
    a = int'(a24) & MASK;
    for (int k = 0; k < d.size(); k++) begin
      if (mdl_mode == 0 && k > 0) break;
      mdl_mem[a] = d[k];
      a = adv(a);
    end
  endtask

  task automatic do_read(input logic [23:0] a24, input int n,
                         input int hk, input int hidx, input string rq);
    logic eb[$]; logic eo[$]; logic ek[$];
    int a;
    logic [7:0] v;
    cur_req = rq;
    a = int'(a24) & MASK;
    for (int k = 0; k < n; k++) begin
      bit live, kn;
      live = !(mdl_mode == 0 && k > 0);
      kn   = mdl_mem.exists(a);
      v    = kn ? mdl_mem[a] : 8'h00;
      for (int i = 7; i >= 0; i--) begin eb.push_back(v[i]); eo.push_back(live); ek.push_back(kn); end
      a = adv(a);
    end
    cs_low(); send_byte(8'h03); send_addr(a24);
    for (int x = 0; x < n * 8; x++) begin
      fall_half(1'b0, eo[x], eb[x], ek[x]);
      if (hk == 1 && hidx == x) pause_low(1'b0);
      rise_half();
      if (hk == 2 && hidx == x) begin
        // pause requested with SCK high: the next fall still takes effect (R11)
        @(negedge clk); hold_n = 1'b0; exp_oe = 1'b0; settle = 2; wait_n(3);
        @(negedge clk); sck = 1'b0; settle = 2; wait_n(3);
        for (int p = 0; p < 2; p++) begin
          @(negedge clk); sck = 1'b1; settle = 2; wait_n(2);
          @(negedge clk); sck = 1'b0; settle = 2; wait_n(2);
        end
        @(negedge clk); hold_n = 1'b1; exp_oe = eo[x+1]; exp_so = eb[x+1]; exp_kn = ek[x+1];
        settle = 2; wait_n(3);
      end
    end
    cs_high();
  endtask

  task automatic do_wrmr(input logic [7:0] v, input string rq);
    cur_req = rq;
    cs_low(); send_byte(8'h01); send_byte(v); cs_high();
    mdl_mode = int'(v[7:6]);
  endtask

  task automatic do_rdmr(input string rq);
    logic [7:0] e;
    cur_req = rq;
    e = {2'(mdl_mode), 6'b0};
    cs_low(); send_byte(8'h05);
    for (int i = 7; i >= 0; i--) begin fall_half(1'b0, 1'b1, e[i], 1'b1); rise_half(); end
    cs_high();
  endtask

  task automatic check_bit(input string rq, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", rq, act, exp);
    end
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    cmp_on = 1'b1;
    check_bit("R9 reset", so_oe, 1'b0);

    // R9: chip select held low since reset, command must be ignored
    cur_req = "R9";
    send_byte(8'h01); send_byte(8'h00); cs_high();
    do_rdmr("R5 reset default");

    // R1 R3 basic write/read in sequential mode
    do_write(24'h000100, '{8'h55, 8'h77}, 0, 0, 0, "R1");
    do_read(24'h000100, 2, 0, 0, "R3");

    // R4 partial byte discarded
    do_write(24'h000200, '{8'h12, 8'h34}, 0, 0, 0, "R4");
    do_write(24'h000200, '{8'hAB}, 0, 0, 4, "R4");
    do_read(24'h000200, 2, 0, 0, "R4");

    // R2 upper address bits ignored
    do_write(24'hFED123, '{8'hC3}, 0, 0, 0, "R2");
    do_read(24'h000123, 1, 0, 0, "R2");

    // R10 pause during write and during read
    do_write(24'h000300, '{8'hA5, 8'h3C}, 1, 5, 0, "R10");
    do_read(24'h000300, 2, 1, 10, "R10");
    // R11 deferred pause during read
    do_read(24'h000300, 2, 2, 3, "R11");

    // R12 undefined opcodes
    cur_req = "R12";
    cs_low(); send_byte(8'hFF); send_byte(8'h01); send_byte(8'h00); cs_high();
    cs_low(); send_byte(8'h9C); send_byte(8'h02); send_addr(24'h000100); send_byte(8'h00); cs_high();
    do_rdmr("R12");
    do_read(24'h000100, 2, 0, 0, "R12");

    // R7 page wrap
    do_wrmr(8'h80, "R7");
    do_write(24'h00005E, '{8'h01, 8'h02, 8'h03, 8'h04}, 0, 0, 0, "R7");
    do_read(24'h00005E, 4, 0, 0, "R7");

    // R5 reserved bits read as zero
    do_wrmr(8'hBF, "R5");
    do_rdmr("R5");

    // R8 sequential: page crossing and rollover
    do_wrmr(8'h40, "R8");
    do_write(24'h00003E, '{8'h10, 8'h20, 8'h30, 8'h40}, 0, 0, 0, "R8");
    do_read(24'h00003E, 4, 0, 0, "R8");
    do_write(24'h0007FE, '{8'hE1, 8'hE2, 8'hE3}, 0, 0, 0, "R8");
    do_read(24'h0007FE, 3, 0, 0, "R8");

    // R6 byte mode
    do_wrmr(8'h00, "R6");
    do_rdmr("R6");
    do_write(24'h000100, '{8'h11, 8'h22}, 0, 0, 0, "R6");
    do_read(24'h000100, 2, 0, 0, "R6");
    do_wrmr(8'h40, "R6");
    do_read(24'h000100, 2, 0, 0, "R6");

    // R5 reserved mode value advances like sequential
    do_wrmr(8'hC0, "R5");
    do_rdmr("R5");
    do_write(24'h00021F, '{8'h5A, 8'hA5}, 0, 0, 0, "R5");
    do_wrmr(8'h40, "R5");
    do_read(24'h00021F, 2, 0, 0, "R5");

    check_bit("R9 idle", so_oe, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule